// File: doc/BRIEF.md
# Clock Output Shutdown and Restart Sequencer

This block sequences the orderly stop and restart of a clock generator's two outputs: a divided main output and a buffered reference output. It decides which reference source the master clock comes from. It produces the enable and drive controls for both outputs, and it gates the oscillator. Everything runs in the master clock domain. The levels of the two outputs are fed back in so that each gate closes only while its output is low. Gating therefore never cuts a pulse short.

One configuration bit fixes the meaning of a shared mode pin. With the bit clear, the pin chooses the reference source on the fly. With the bit set, a low pin asks for power-down, and a second configuration bit chooses the source while the pin is high. Power-down closes the main output first, then the reference output, then stops the oscillator and releases both outputs to high impedance. Releasing the pin restarts the oscillator. The sequencer then waits a fixed number of cycles (`WAKE_CYCLES`) before it brings back the reference output and then the main output. A third configuration bit can keep the reference output off for good.

Top module: `clkout_pwr_seq`

## Requirements
- R1: During and just after reset, `seq_state` is RUN (code 0), `osc_en` and `main_drive` are 1, and `ref_gate_en`, `ref_drive`, `main_gate_en` are 0. With `cfg_ref_off`=0, `ref_gate_en` and `ref_drive` become 1 after the first clock edge and `main_gate_en` becomes 1 after the second.
- R2: With `cfg_pdown_mode`=0, `ref_ext` equals the inverse of `mode_pin` one cycle later (pin high selects internal, 0; pin low selects external, 1), whatever `cfg_ext_ref` is.
- R3: With `cfg_pdown_mode`=1 and `mode_pin` high, `ref_ext` follows `cfg_ext_ref` one cycle later (0 internal, 1 external). While the pin is low, `ref_ext` holds its last value.
- R4: With `cfg_pdown_mode`=1, a low `mode_pin` moves RUN to STOP_OUT (code 1) at the next edge. `main_gate_en` falls only at an edge where `main_level` was low beforehand, and the state then moves to STOP_REF (code 2).
- R5: In STOP_REF, `ref_gate_en` falls only at an edge where `ref_level` was low beforehand, and the state then moves to OFF (code 3). `main_gate_en` is already 0 by then.
- R6: One cycle after entering OFF with the request still present, `osc_en`, `main_drive` and `ref_drive` are all 0, so both outputs are high impedance.
- R7: With `cfg_ref_off`=1, `ref_drive` and `ref_gate_en` stay 0. `main_gate_en` rises one cycle after reset. STOP_REF is left at its first edge even while `ref_level` is high.
- R8: When the request is removed in OFF, the state moves to WAKE (code 4) with `osc_en` 1 and both drives 0, and it stays in WAKE for exactly `WAKE_CYCLES` cycles. It then returns to RUN with `ref_gate_en`, `ref_drive` and `main_drive` at 1, and `main_gate_en` rises one cycle later.
- R9: With `cfg_pdown_mode`=0, a low `mode_pin` never leaves RUN and never clears `osc_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset |
| cfg_pdown_mode | input | 1 | 1: shared pin requests power-down; 0: pin selects the reference |
| cfg_ref_off | input | 1 | 1: reference output permanently off |
| cfg_ext_ref | input | 1 | Reference choice in power-down mode (1 external) |
| mode_pin | input | 1 | Shared power-down / select pin |
| main_level | input | 1 | Present level of the main output |
| ref_level | input | 1 | Present level of the reference output |
| ref_ext | output | 1 | Reference mux select (1 external) |
| osc_en | output | 1 | Oscillator enable |
| main_gate_en | output | 1 | Main output clock gate |
| main_drive | output | 1 | Main output driver enable (0 = high impedance) |
| ref_gate_en | output | 1 | Reference output clock gate |
| ref_drive | output | 1 | Reference output driver enable (0 = high impedance) |
| seq_state | output | 3 | Sequencer state code |

## Verification
The assertions assume that the three configuration bits change only while reset is held, and that `mode_pin` and both level inputs are already synchronous to the master clock. The glitch checks also take the level inputs as true reports of the outputs. The bench changes configuration only inside its reset task. It drives every input on the falling clock edge, and it keeps each output level high for several cycles before lowering it, so that the gates are seen to wait.

// File: rtl/clkout_pwr_seq_pkg.sv
package clkout_pwr_seq_pkg;

    typedef enum logic [2:0] {
        ST_RUN      = 3'd0,
        ST_STOP_OUT = 3'd1,
        ST_STOP_REF = 3'd2,
        ST_OFF      = 3'd3,
        ST_WAKE     = 3'd4
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       osc_en;
        logic       main_en;
        logic       main_oe;
        logic       ref_en;
        logic       ref_oe;
    } seq_regs_t;

endpackage

// File: rtl/cps_ref_select.sv
module cps_ref_select (
    input  logic clk,
    input  logic rst_n,
    input  logic pd_mode,
    input  logic pin,
    input  logic ext_bit,
    output logic ref_ext
);
    logic ext_d, ext_q;

    always_comb begin
        ext_d = ext_q;
        if (!pd_mode) begin
            ext_d = ~pin;
        end else if (pin) begin
            ext_d = ext_bit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ext_q <= 1'b0;
        else        ext_q <= ext_d;
    end

    assign ref_ext = ext_q;
endmodule

// File: rtl/cps_wake_timer.sv
module cps_wake_timer #(
    parameter int WAKE_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);
    localparam int CW = (WAKE_CYCLES < 2) ? 1 : $clog2(WAKE_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(WAKE_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = '0;
        if (run && cnt_q != LAST) cnt_d = cnt_q + 1'b1;
        else if (run)             cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/clkout_pwr_seq.sv
module clkout_pwr_seq
    import clkout_pwr_seq_pkg::*;
#(
    parameter int WAKE_CYCLES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_pdown_mode,
    input  logic       cfg_ref_off,
    input  logic       cfg_ext_ref,
    input  logic       mode_pin,
    input  logic       main_level,
    input  logic       ref_level,
    output logic       ref_ext,
    output logic       osc_en,
    output logic       main_gate_en,
    output logic       main_drive,
    output logic       ref_gate_en,
    output logic       ref_drive,
    output logic [2:0] seq_state
);
    seq_regs_t r_d, r_q;
    logic      pd_req;
    logic      wake_done;

    cps_ref_select u_sel (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_mode (cfg_pdown_mode),
        .pin     (mode_pin),
        .ext_bit (cfg_ext_ref),
        .ref_ext (ref_ext)
    );

    cps_wake_timer #(.WAKE_CYCLES(WAKE_CYCLES)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (r_q.state == ST_WAKE),
        .done  (wake_done)
    );

    assign pd_req = cfg_pdown_mode & ~mode_pin;

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_RUN: begin
                r_d.osc_en  = 1'b1;
                r_d.main_oe = 1'b1;
                r_d.ref_en  = ~cfg_ref_off;
                r_d.ref_oe  = ~cfg_ref_off;
                if (pd_req) begin
                    r_d.state = ST_STOP_OUT;
                end else begin
                    // main comes up only once the reference path is settled
                    r_d.main_en = r_q.ref_en | cfg_ref_off;
                end
            end
            ST_STOP_OUT: begin
                if (!main_level || !r_q.main_en) begin
                    r_d.main_en = 1'b0;
                    r_d.state   = ST_STOP_REF;
                end
            end
            ST_STOP_REF: begin
                if (!ref_level || !r_q.ref_en) begin
                    r_d.ref_en = 1'b0;
                    r_d.state  = ST_OFF;
                end
            end
            ST_OFF: begin
                r_d.osc_en  = 1'b0;
                r_d.main_oe = 1'b0;
                r_d.ref_oe  = 1'b0;
                if (!pd_req) begin
                    r_d.osc_en = 1'b1;
                    r_d.state  = ST_WAKE;
                end
            end
            ST_WAKE: begin
                r_d.osc_en  = 1'b1;
                r_d.main_oe = 1'b0;
                r_d.ref_oe  = 1'b0;
                if (wake_done) begin
                    r_d.ref_en  = ~cfg_ref_off;
                    r_d.ref_oe  = ~cfg_ref_off;
                    r_d.main_oe = 1'b1;
                    r_d.state   = ST_RUN;
                end
            end
            default: r_d.state = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_RUN;
            r_q.osc_en  <= 1'b1;
            r_q.main_en <= 1'b0;
            r_q.main_oe <= 1'b1;
            r_q.ref_en  <= 1'b0;
            r_q.ref_oe  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign osc_en       = r_q.osc_en;
    assign main_gate_en = r_q.main_en;
    assign main_drive   = r_q.main_oe;
    assign ref_gate_en  = r_q.ref_en;
    assign ref_drive    = r_q.ref_oe;
    assign seq_state    = r_q.state;
endmodule

// File: rtl/clkout_pwr_seq_chk.sv
module clkout_pwr_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_pdown_mode,
    input logic       cfg_ref_off,
    input logic       mode_pin,
    input logic       main_level,
    input logic       ref_level,
    input logic       ref_ext,
    input logic       osc_en,
    input logic       main_gate_en,
    input logic       main_drive,
    input logic       ref_gate_en,
    input logic       ref_drive,
    input logic [2:0] seq_state
);
    p_main_no_runt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(main_gate_en) |-> !$past(main_level));

    p_ref_no_runt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ref_gate_en) |-> (!$past(ref_level) && !main_gate_en));

    p_osc_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en) |-> (!main_gate_en && !ref_gate_en && !main_drive && !ref_drive));

    p_ref_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ref_off && $past(cfg_ref_off)) |-> (!ref_drive && !ref_gate_en));

    p_main_after_ref_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_gate_en) |-> (ref_gate_en || cfg_ref_off));

    p_select_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pdown_mode && !$past(cfg_pdown_mode)) |-> (ref_ext == !$past(mode_pin)));

    p_select_no_pd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_pdown_mode && !$past(cfg_pdown_mode)) |-> (osc_en && seq_state == 3'd0));
endmodule

bind clkout_pwr_seq clkout_pwr_seq_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_pdown_mode (cfg_pdown_mode),
    .cfg_ref_off    (cfg_ref_off),
    .mode_pin       (mode_pin),
    .main_level     (main_level),
    .ref_level      (ref_level),
    .ref_ext        (ref_ext),
    .osc_en         (osc_en),
    .main_gate_en   (main_gate_en),
    .main_drive     (main_drive),
    .ref_gate_en    (ref_gate_en),
    .ref_drive      (ref_drive),
    .seq_state      (seq_state)
);

// File: tb/clkout_pwr_seq_test.sv
module clkout_pwr_seq_test;
    localparam int WAKE = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_pdown_mode = 1'b1, cfg_ref_off = 1'b0, cfg_ext_ref = 1'b0;
    logic mode_pin = 1'b1, main_level = 1'b1, ref_level = 1'b1;
    logic ref_ext, osc_en, main_gate_en, main_drive, ref_gate_en, ref_drive;
    logic [2:0] seq_state;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    clkout_pwr_seq #(.WAKE_CYCLES(WAKE)) uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_pdown_mode(cfg_pdown_mode), .cfg_ref_off(cfg_ref_off),
        .cfg_ext_ref(cfg_ext_ref), .mode_pin(mode_pin),
        .main_level(main_level), .ref_level(ref_level),
        .ref_ext(ref_ext), .osc_en(osc_en), .main_gate_en(main_gate_en),
        .main_drive(main_drive), .ref_gate_en(ref_gate_en),
        .ref_drive(ref_drive), .seq_state(seq_state)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset(input logic pdm, input logic roff, input logic ext);
        @(negedge clk);
        rst_n = 1'b0;
        cfg_pdown_mode = pdm; cfg_ref_off = roff; cfg_ext_ref = ext;
        mode_pin = 1'b1; main_level = 1'b1; ref_level = 1'b1;
        tick(2);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_r1();
        do_reset(1'b1, 1'b0, 1'b0);
        chk("R1 state", seq_state, 0);
        chk("R1 osc", osc_en, 1);
        chk("R1 main_drive", main_drive, 1);
        chk("R1 ref_gate", ref_gate_en, 0);
        chk("R1 main_gate", main_gate_en, 0);
        tick(1);
        chk("R1 ref_gate up", ref_gate_en, 1);
        chk("R1 ref_drive up", ref_drive, 1);
        chk("R1 main_gate still low", main_gate_en, 0);
        tick(1);
        chk("R1 main_gate up", main_gate_en, 1);
    endtask

    task automatic t_select_r2_r9();
        do_reset(1'b0, 1'b0, 1'b0);
        cfg_ext_ref = 1'b0;
        mode_pin = 1'b0; tick(1);
        chk("R2 pin low ext", ref_ext, 1);
        tick(3);
        chk("R9 state", seq_state, 0);
        chk("R9 osc", osc_en, 1);
        mode_pin = 1'b1; tick(1);
        chk("R2 pin high int", ref_ext, 0);
    endtask

    task automatic t_eibit_r3();
        do_reset(1'b1, 1'b0, 1'b1);
        tick(1);
        chk("R3 ext bit 1", ref_ext, 1);
        mode_pin = 1'b0; tick(3);
        chk("R3 hold in pd", ref_ext, 1);
        do_reset(1'b1, 1'b0, 1'b0);
        tick(1);
        chk("R3 ext bit 0", ref_ext, 0);
    endtask

    task automatic t_powerdown_r4_r8();
        do_reset(1'b1, 1'b0, 1'b0);
        tick(3);
        mode_pin = 1'b0; tick(1);
        chk("R4 stop_out", seq_state, 1);
        tick(3);
        chk("R4 main waits", main_gate_en, 1);
        chk("R4 still stop_out", seq_state, 1);
        main_level = 1'b0; tick(1);
        chk("R4 main gated", main_gate_en, 0);
        chk("R4 stop_ref", seq_state, 2);
        tick(2);
        chk("R5 ref waits", ref_gate_en, 1);
        ref_level = 1'b0; tick(1);
        chk("R5 ref gated", ref_gate_en, 0);
        chk("R5 off", seq_state, 3);
        tick(1);
        chk("R6 osc off", osc_en, 0);
        chk("R6 main hiz", main_drive, 0);
        chk("R6 ref hiz", ref_drive, 0);
        main_level = 1'b1; ref_level = 1'b1;
        mode_pin = 1'b1;
        for (int i = 0; i < WAKE; i++) begin
            tick(1);
            chk("R8 wake", seq_state, 4);
            chk("R8 osc on", osc_en, 1);
            chk("R8 drive low", main_drive, 0);
        end
        tick(1);
        chk("R8 run", seq_state, 0);
        chk("R8 ref back", ref_gate_en, 1);
        chk("R8 main drive", main_drive, 1);
        chk("R8 main not yet", main_gate_en, 0);
        tick(1);
        chk("R8 main back", main_gate_en, 1);
    endtask

    task automatic t_refoff_r7();
        do_reset(1'b1, 1'b1, 1'b0);
        tick(1);
        chk("R7 main up", main_gate_en, 1);
        chk("R7 ref drive", ref_drive, 0);
        chk("R7 ref gate", ref_gate_en, 0);
        main_level = 1'b0; ref_level = 1'b1;
        mode_pin = 1'b0; tick(3);
        chk("R7 off despite ref high", seq_state, 3);
    endtask

    initial begin
        t_reset_r1();
        t_select_r2_r9();
        t_eibit_r3();
        t_powerdown_r4_r8();
        t_refoff_r7();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule